// File: doc/BRIEF.md
# Serial Fault Code Broadcaster

This block turns six separate fault flags into a single serial fault pin that a host can decode. Each fault has a fixed 16-bit signature. The signatures of all faults that are active at the same time are merged with a bitwise OR, and the merged word is shifted out on the pin over and over. When no fault is present the word is zero, so the pin stays low.

Bits leave at a slow rate set by an internal clock divider. The divider raises a one-cycle tick every `DIV_RATIO` clocks, and each tick moves the pin on by one bit, most significant bit first. The fault flags are read only at the first bit of each frame, so a frame never mixes two fault states. A frame marker output is high while bit 15 of each frame is on the pin, which lets a tester find the frame boundaries.

The fault flags are expected to be synchronized, level-type digital inputs. Analog sensing and hysteresis are done elsewhere.

Top module: `fault_code_broadcaster`

## Requirements
- R1: While reset is asserted and after it is released, until the first divider tick, both `fault_pin` and `frame_mark` are low.
- R2: When no fault flag is set at a frame start, all 16 bits of that frame are 0.
- R3: With exactly one fault set, the frame is 16'hF00A with one more bit set. Flag index i selects bit 10-i: 0 battery low (bit 10), 1 battery high (bit 9), 2 supply low (bit 8), 3 supply high (bit 7), 4 temperature warning (bit 6), 5 temperature trip (bit 5).
- R4: With several faults set, the frame is the bitwise OR of the single-fault signatures of those faults.
- R5: Bits go out MSB first, one bit per divider tick. Each bit stays on the pin for exactly `DIV_RATIO` clock cycles.
- R6: The flags are sampled only at the tick that starts a frame. A flag change in the middle of a frame has no effect on that frame and first shows in the next frame.
- R7: `frame_mark` is high for exactly the `DIV_RATIO` cycles during which bit 15 is on the pin and low otherwise. Frames follow each other with no gap, so frame starts are 16*`DIV_RATIO` cycles apart.
- R8: While the flags stay the same, every frame repeats the same word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flt_bat_low | input | 1 | Battery undervoltage flag (index 0) |
| flt_bat_high | input | 1 | Battery overvoltage flag (index 1) |
| flt_sup_low | input | 1 | Supply undervoltage flag (index 2) |
| flt_sup_high | input | 1 | Supply overvoltage flag (index 3) |
| flt_temp_warn | input | 1 | Temperature warning flag (index 4) |
| flt_temp_trip | input | 1 | Over-temperature flag (index 5) |
| fault_pin | output | 1 | Serial fault code, MSB first |
| frame_mark | output | 1 | High while bit 15 of a frame is on the pin |

## Verification
All 64 combinations of the six flags are swept. Each full frame is compared with a word the bench builds from the signature rule. The all-zero case separates a silent pin from the fixed header. The single-flag cases show that each fault lands on its own bit, and the multi-flag cases show OR merging rather than priority or overwrite. In a separate test the flags change halfway through a frame, which tells sampling at the frame start apart from live sampling. Repeated frames with unchanged flags check that the word repeats, and frame marker timing checks frame alignment and the bit period.

// File: rtl/fcb_pkg.sv
package fcb_pkg;
   localparam int unsigned FRAME_W    = 16;
   localparam int unsigned NUM_FAULTS = 6;
   localparam int unsigned BIT_CNT_W  = $clog2(FRAME_W);

   // Fixed header and trailer shared by every nonzero signature.
   localparam logic [FRAME_W-1:0] SIG_FRAME = 16'hF00A;
   // Bit position of the fault with index 0; later faults sit one lower each.
   localparam int unsigned FIRST_FAULT_BIT = 10;

   typedef enum logic [2:0] {
      FLT_BAT_LOW   = 3'd0,
      FLT_BAT_HIGH  = 3'd1,
      FLT_SUP_LOW   = 3'd2,
      FLT_SUP_HIGH  = 3'd3,
      FLT_TEMP_WARN = 3'd4,
      FLT_TEMP_TRIP = 3'd5
   } fault_idx_e;

   function automatic logic [FRAME_W-1:0] fault_signature(input int unsigned idx);
      logic [FRAME_W-1:0] sig;
      sig = SIG_FRAME;
      sig[FIRST_FAULT_BIT - idx] = 1'b1;
      return sig;
   endfunction
endpackage

// File: rtl/fcb_bit_divider.sv
module fcb_bit_divider #(
   parameter int unsigned DIV_RATIO = 100
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   localparam int unsigned CNT_W = (DIV_RATIO > 1) ? $clog2(DIV_RATIO) : 1;
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DIV_RATIO - 1);

   generate
      if (DIV_RATIO < 1) begin : g_bad_ratio
         $error("fcb_bit_divider: DIV_RATIO must be at least 1");
      end
      if (DIV_RATIO == 1) begin : g_full_rate
         // Every clock is a bit slot; no counter needed.
         assign tick = rst_n;
      end else begin : g_counted
         logic [CNT_W-1:0] cnt_q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (cnt_q == CNT_LAST) begin
               cnt_q <= '0;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end

         assign tick = (cnt_q == CNT_LAST);

         // R5: the counter never leaves its range
         a_r5_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_q <= CNT_LAST);
         // R5: a tick is followed by a quiet cycle when the ratio exceeds one
         a_r5_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
            tick |=> !tick);
      end
   endgenerate
endmodule

// File: rtl/fcb_code_merge.sv
module fcb_code_merge
   import fcb_pkg::*;
(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_FAULTS-1:0] flags,
   output logic [FRAME_W-1:0]    word
);
   logic [FRAME_W-1:0] masked [NUM_FAULTS];

   generate
      if (FIRST_FAULT_BIT + 1 < NUM_FAULTS) begin : g_bad_layout
         $error("fcb_code_merge: fault bits do not fit below FIRST_FAULT_BIT");
      end
      for (genvar g = 0; g < NUM_FAULTS; g++) begin : g_sig
         localparam logic [FRAME_W-1:0] SIG = fault_signature(g);
         assign masked[g] = flags[g] ? SIG : '0;

         // R4: an active fault's signature is fully contained in the word
         a_r4_contains_sig: assert property (@(posedge clk) disable iff (!rst_n)
            flags[g] |-> ((word & SIG) == SIG));
         // R3: an inactive fault's own bit is absent from the word
         a_r3_bit_absent: assert property (@(posedge clk) disable iff (!rst_n)
            !flags[g] |-> !word[FIRST_FAULT_BIT - g]);
      end
   endgenerate

   always_comb begin
      word = '0;
      for (int i = 0; i < NUM_FAULTS; i++) begin
         word = word | masked[i];
      end
   end

   // R2: no fault means a silent word
   a_r2_quiet_word: assert property (@(posedge clk) disable iff (!rst_n)
      (flags == '0) |-> (word == '0));
endmodule

// File: rtl/fcb_frame_shifter.sv
module fcb_frame_shifter
   import fcb_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick,
   input  logic [FRAME_W-1:0] word,
   output logic               ser_out,
   output logic               frame_mark
);
   logic [FRAME_W-1:0]   shreg_q;
   logic [BIT_CNT_W-1:0] left_q;
   logic                 at_start;

   assign at_start = (left_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shreg_q    <= '0;
         left_q     <= '0;
         ser_out    <= 1'b0;
         frame_mark <= 1'b0;
      end else if (tick) begin
         if (at_start) begin
            ser_out    <= word[FRAME_W-1];
            shreg_q    <= {word[FRAME_W-2:0], 1'b0};
            left_q     <= BIT_CNT_W'(FRAME_W - 1);
            frame_mark <= 1'b1;
         end else begin
            ser_out    <= shreg_q[FRAME_W-1];
            shreg_q    <= {shreg_q[FRAME_W-2:0], 1'b0};
            left_q     <= left_q - 1'b1;
            frame_mark <= 1'b0;
         end
      end
   end

   // R5: pin only moves on a tick
   a_r5_hold_bit: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(ser_out));
   // R7: marker only moves on a tick
   a_r7_hold_mark: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(frame_mark));
   // R7: a frame start raises the marker
   a_r7_mark_at_start: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && at_start) |=> frame_mark);
   // R2: a zero word loaded at frame start gives a low first bit
   a_r2_zero_first: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && at_start && word == '0) |=> !ser_out);
endmodule

// File: rtl/fault_code_broadcaster.sv
module fault_code_broadcaster #(
   parameter int unsigned DIV_RATIO = 100
) (
   input  logic clk,
   input  logic rst_n,
   input  logic flt_bat_low,
   input  logic flt_bat_high,
   input  logic flt_sup_low,
   input  logic flt_sup_high,
   input  logic flt_temp_warn,
   input  logic flt_temp_trip,
   output logic fault_pin,
   output logic frame_mark
);
   import fcb_pkg::*;

   logic [NUM_FAULTS-1:0] flags;
   logic [FRAME_W-1:0]    word;
   logic                  tick;

   always_comb begin
      flags                = '0;
      flags[FLT_BAT_LOW]   = flt_bat_low;
      flags[FLT_BAT_HIGH]  = flt_bat_high;
      flags[FLT_SUP_LOW]   = flt_sup_low;
      flags[FLT_SUP_HIGH]  = flt_sup_high;
      flags[FLT_TEMP_WARN] = flt_temp_warn;
      flags[FLT_TEMP_TRIP] = flt_temp_trip;
   end

   fcb_bit_divider #(.DIV_RATIO(DIV_RATIO)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick)
   );

   fcb_code_merge u_merge (
      .clk   (clk),
      .rst_n (rst_n),
      .flags (flags),
      .word  (word)
   );

   fcb_frame_shifter u_shift (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (tick),
      .word       (word),
      .ser_out    (fault_pin),
      .frame_mark (frame_mark)
   );

   // R1: outputs are low in the cycle after reset
   a_r1_reset_quiet: assert property (@(posedge clk)
      !rst_n |=> (!fault_pin && !frame_mark));
endmodule

// File: tb/sim_fault_code_broadcaster.sv
module sim_fault_code_broadcaster;
   localparam int DIV = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [5:0] flags = '0;
   logic       fault_pin, frame_mark;
   int         checks = 0;
   int         failures = 0;
   bit         done = 1'b0;

   always #10 clk = ~clk;

   fault_code_broadcaster #(.DIV_RATIO(DIV)) u0 (
      .clk(clk), .rst_n(rst_n),
      .flt_bat_low(flags[0]), .flt_bat_high(flags[1]),
      .flt_sup_low(flags[2]), .flt_sup_high(flags[3]),
      .flt_temp_warn(flags[4]), .flt_temp_trip(flags[5]),
      .fault_pin(fault_pin), .frame_mark(frame_mark)
   );

   function automatic logic [15:0] expect_word(input logic [5:0] v);
      logic [15:0] w;
      if (v == 6'd0) return 16'h0000;
      w = 16'hF00A;
      for (int i = 0; i < 6; i++) if (v[i]) w = w | (16'h1 << (10 - i));
      return w;
   endfunction

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wait_frame_start();
      while (frame_mark) @(negedge clk);
      while (!frame_mark) @(negedge clk);
   endtask

   // Reads one frame starting at the current negedge (marker just rose);
   // checks bit hold (R5) and marker timing (R7) on the way.
   task automatic read_frame(output logic [15:0] w, input int chg_bit, input logic [5:0] chg_val);
      bit hold_ok = 1'b1;
      bit mark_ok = 1'b1;
      for (int b = 15; b >= 0; b--) begin
         w[b] = fault_pin;
         if (b == chg_bit) flags = chg_val;
         for (int c = 0; c < DIV; c++) begin
            if (fault_pin !== w[b]) hold_ok = 1'b0;
            if (frame_mark !== (b == 15)) mark_ok = 1'b0;
            @(negedge clk);
         end
      end
      check(hold_ok, "R5 bit held DIV cycles", 32'(hold_ok), 32'd1);
      check(mark_ok, "R7 marker only on bit 15", 32'(mark_ok), 32'd1);
      // Back-to-back frames: the next marker is already high here.
      check(frame_mark === 1'b1, "R7 no gap between frames", 32'(frame_mark), 32'd1);
   endtask

   initial begin
      #(20 * 200000);
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog expired");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [15:0] w, w2;
      repeat (3) @(negedge clk);
      check(fault_pin === 1'b0, "R1 pin low in reset", 32'(fault_pin), 32'd0);
      check(frame_mark === 1'b0, "R1 mark low in reset", 32'(frame_mark), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check(fault_pin === 1'b0 && frame_mark === 1'b0, "R1 low before first tick",
            32'({fault_pin, frame_mark}), 32'd0);

      // Sweep all flag combinations (R2, R3, R4)
      for (int v = 0; v < 64; v++) begin
         flags = 6'(v);
         wait_frame_start();
         read_frame(w, -1, 6'd0);
         if (v == 0)
            check(w === 16'h0000, "R2 zero frame", 32'(w), 32'h0);
         else if ($countones(6'(v)) == 1)
            check(w === expect_word(6'(v)), "R3 single fault signature", 32'(w), 32'(expect_word(6'(v))));
         else
            check(w === expect_word(6'(v)), "R4 OR of signatures", 32'(w), 32'(expect_word(6'(v))));
      end

      // R8: repetition with steady flags
      flags = 6'b010010;
      wait_frame_start();
      read_frame(w, -1, 6'd0);
      read_frame(w2, -1, 6'd0);
      check(w2 === w && w === expect_word(6'b010010), "R8 frame repeats", 32'(w2), 32'(w));

      // R6: change mid-frame, current frame unchanged, next one updated
      flags = 6'b000001;
      wait_frame_start();
      read_frame(w, 8, 6'b100100);
      check(w === expect_word(6'b000001), "R6 mid-frame change ignored", 32'(w), 32'(expect_word(6'b000001)));
      read_frame(w2, -1, 6'd0);
      check(w2 === expect_word(6'b100100), "R6 change seen next frame", 32'(w2), 32'(expect_word(6'b100100)));

      // R6: clearing all faults mid-frame
      read_frame(w, 3, 6'd0);
      check(w === expect_word(6'b100100), "R6 clear mid-frame ignored", 32'(w), 32'(expect_word(6'b100100)));
      read_frame(w2, -1, 6'd0);
      check(w2 === 16'h0000, "R2 silent after clear", 32'(w2), 32'h0);

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule